// File: doc/BRIEF.md
# DS3 Transmit Overhead Port Merger

This block is the last stage on the transmit DS3 bit stream. One bit enters per clock together with a description of where that bit sits in the frame: whether it is an overhead slot, which kind of overhead slot it is, and whether it is the first overhead slot of a multiframe. Payload bits leave unchanged in the same cycle. On overhead slots an external serial source may take over the bit. When the source raises its enable, the bit it supplies replaces the X, F, M or C bit. On P slots the supplied bit is XORed into the parity bit, which lets the source inject parity errors. Whatever the earlier stages put in an overhead slot is overridden by the external bit.

To pace the external source, the block gives it a port clock pulse on every overhead slot it serves and a start-of-multiframe marker on the first one. A two-state machine follows the overhead slot count. In `ST_HUNT` the block has no multiframe reference, so it issues no port clocks and inserts nothing. An overhead slot flagged as the multiframe start moves it to `ST_ALIGNED` (transition `HUNT_TO_ALIGNED`). In `ST_ALIGNED` it counts overhead slots. A new start flag restarts the count (transition `ALIGNED_REALIGN`). If the count reaches 56 and another overhead slot arrives without a start flag, the block returns to `ST_HUNT` (transition `ALIGNED_TO_HUNT`). Otherwise it stays in `ST_ALIGNED` (transition `ALIGNED_STAY`).

Top module: `ds3_ohp_merge_top`

## Requirements
- R1: When `slot_oh` is low, `line_out` equals `line_in` in the same cycle, whatever `ext_en`, `ext_bit` and `mf_mark` are.
- R2: On an active overhead slot with `ext_en` high and `slot_kind` other than 1, `line_out` equals `ext_bit` in the same cycle. The kind codes are X=0, P=1, M=2, F=3 and C=4. Codes 5 to 7 are treated like replacement kinds.
- R3: On an active overhead slot with `ext_en` high and `slot_kind` equal to 1 (P), `line_out` equals `line_in` XOR `ext_bit`.
- R4: When `ext_en` is low, `line_out` equals `line_in` on every slot.
- R5: `port_clk` is high in exactly those cycles that are active overhead slots. A slot is active when `slot_oh` is high and either `mf_mark` is high, or the block is aligned and fewer than 56 overhead slots have passed since the last start.
- R6: `port_sof` is high exactly when `slot_oh` and `mf_mark` are both high. It is high only together with `port_clk`.
- R7: After reset and before the first flagged start, no overhead slot is active: `port_clk` stays low and nothing is inserted.
- R8: When the 57th overhead slot after a start arrives without `mf_mark`, that slot and all later slots are inactive until the next flagged start.
- R9: `mf_mark` has no effect in a cycle where `slot_oh` is low. It neither aligns nor restarts the count.
- R10: A flagged start while aligned restarts the count, so that 56 active slots follow from the new start.
- R11: While `rst_n` is low the block is held in hunt: `port_clk` and `port_sof` are low for unflagged slots, and `line_out` equals `line_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the transmit stream |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Incoming serial DS3 bit |
| slot_oh | input | 1 | Current bit is an overhead slot |
| slot_kind | input | 3 | Overhead kind: 0 X, 1 P, 2 M, 3 F, 4 C |
| mf_mark | input | 1 | Current overhead slot is the first of a multiframe |
| ext_bit | input | 1 | Bit from the external overhead source |
| ext_en | input | 1 | External source claims the current slot |
| line_out | output | 1 | Outgoing serial DS3 bit |
| port_clk | output | 1 | Pulse on each served overhead slot |
| port_sof | output | 1 | Marks the first served slot of a multiframe |

## Verification
Every output is due in the same cycle as its stimulus. `line_out`, `port_clk` and `port_sof` depend combinationally on the current inputs and on the alignment state left by earlier overhead slots. The bench drives a slot on the falling edge and samples all three outputs 1 ns before the next rising edge. After that sample it advances its own model of the state, so an alignment change takes effect from the following overhead slot. Directed runs place the 56th and 57th slots and the mid-frame restarts at known positions.

// File: rtl/ds3_ohp_pkg.sv
package ds3_ohp_pkg;

    // overhead slot kinds carried on slot_kind
    typedef enum logic [2:0] {
        KIND_X = 3'd0,
        KIND_P = 3'd1,
        KIND_M = 3'd2,
        KIND_F = 3'd3,
        KIND_C = 3'd4
    } oh_kind_e;

    // alignment tracker states
    typedef enum logic [0:0] {
        ST_HUNT    = 1'b0,
        ST_ALIGNED = 1'b1
    } align_state_e;

endpackage

// File: rtl/ds3_ohp_track.sv
module ds3_ohp_track
    import ds3_ohp_pkg::*;
#(
    parameter int OH_PER_MF = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_oh,
    input  logic mf_mark,
    output logic slot_active,
    output logic slot_first
);

    localparam int CW = $clog2(OH_PER_MF + 1);
    localparam logic [CW-1:0] LIMIT = CW'(OH_PER_MF);

    align_state_e     state_q, state_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic             start_now;

    assign start_now = slot_oh && mf_mark;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        slot_active = 1'b0;
        slot_first  = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (start_now) begin
                    // HUNT_TO_ALIGNED
                    slot_active = 1'b1;
                    slot_first  = 1'b1;
                    state_d     = ST_ALIGNED;
                    cnt_d       = CW'(1);
                end
            end
            ST_ALIGNED: begin
                if (start_now) begin
                    // ALIGNED_REALIGN
                    slot_active = 1'b1;
                    slot_first  = 1'b1;
                    cnt_d       = CW'(1);
                end else if (slot_oh) begin
                    if (cnt_q < LIMIT) begin
                        // ALIGNED_STAY
                        slot_active = 1'b1;
                        cnt_d       = cnt_q + CW'(1);
                    end else begin
                        // ALIGNED_TO_HUNT
                        state_d = ST_HUNT;
                        cnt_d   = '0;
                    end
                end
            end
            default: begin
                state_d = ST_HUNT;
                cnt_d   = '0;
            end
        endcase
    end

endmodule

// File: rtl/ds3_ohp_mux.sv
module ds3_ohp_mux
    import ds3_ohp_pkg::*;
(
    input  logic       line_in,
    input  logic       slot_active,
    input  logic [2:0] slot_kind,
    input  logic       ext_bit,
    input  logic       ext_en,
    output logic       line_out
);

    logic take;
    logic is_parity;

    assign take      = slot_active && ext_en;
    assign is_parity = (slot_kind == KIND_P);

    always_comb begin
        line_out = line_in;
        if (take) begin
            line_out = is_parity ? (line_in ^ ext_bit) : ext_bit;
        end
    end

endmodule

// File: rtl/ds3_ohp_merge_top.sv
module ds3_ohp_merge_top
    import ds3_ohp_pkg::*;
#(
    parameter int OH_PER_MF = 56
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    input  logic       slot_oh,
    input  logic [2:0] slot_kind,
    input  logic       mf_mark,
    input  logic       ext_bit,
    input  logic       ext_en,
    output logic       line_out,
    output logic       port_clk,
    output logic       port_sof
);

    logic active;
    logic first;

    ds3_ohp_track #(.OH_PER_MF(OH_PER_MF)) track_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_oh     (slot_oh),
        .mf_mark     (mf_mark),
        .slot_active (active),
        .slot_first  (first)
    );

    ds3_ohp_mux mux_i (
        .line_in     (line_in),
        .slot_active (active),
        .slot_kind   (slot_kind),
        .ext_bit     (ext_bit),
        .ext_en      (ext_en),
        .line_out    (line_out)
    );

    assign port_clk = active;
    assign port_sof = first;

endmodule

// File: rtl/ds3_ohp_checker.sv
module ds3_ohp_checker #(
    parameter int OH_PER_MF = 56
) (
    input logic       clk,
    input logic       rst_n,
    input logic       line_in,
    input logic       slot_oh,
    input logic [2:0] slot_kind,
    input logic       mf_mark,
    input logic       ext_bit,
    input logic       ext_en,
    input logic       line_out,
    input logic       port_clk,
    input logic       port_sof
);

    localparam int CW = $clog2(OH_PER_MF + 2);
    localparam logic [CW-1:0] LIMIT = CW'(OH_PER_MF);

    logic [CW-1:0] served_q;

    // port clocks seen since the last start marker, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            served_q <= '0;
        end else if (port_sof) begin
            served_q <= CW'(1);
        end else if (port_clk && served_q <= LIMIT) begin
            served_q <= served_q + CW'(1);
        end
    end

    p_payload_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_oh |-> line_out == line_in);

    p_parity_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (port_clk && ext_en && slot_kind == 3'd1) |-> line_out == (line_in ^ ext_bit));

    p_no_enable_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |-> line_out == line_in);

    p_clk_on_overhead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        port_clk |-> slot_oh);

    p_sof_with_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        port_sof |-> (port_clk && mf_mark));

    p_window_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (port_clk && !port_sof) |-> (served_q != '0 && served_q < LIMIT));

endmodule

bind ds3_ohp_merge_top ds3_ohp_checker #(.OH_PER_MF(OH_PER_MF)) checker_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .slot_oh   (slot_oh),
    .slot_kind (slot_kind),
    .mf_mark   (mf_mark),
    .ext_bit   (ext_bit),
    .ext_en    (ext_en),
    .line_out  (line_out),
    .port_clk  (port_clk),
    .port_sof  (port_sof)
);

// File: tb/ds3_ohp_merge_top_tb_top.sv
`timescale 1ns/1ps
module ds3_ohp_merge_top_tb_top;

    localparam int N = 56;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b0;
    logic       slot_oh = 1'b0;
    logic [2:0] slot_kind = 3'd0;
    logic       mf_mark = 1'b0;
    logic       ext_bit = 1'b0;
    logic       ext_en = 1'b0;
    logic       line_out, port_clk, port_sof;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit m_al = 1'b0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    ds3_ohp_merge_top #(.OH_PER_MF(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .slot_oh(slot_oh),
        .slot_kind(slot_kind), .mf_mark(mf_mark), .ext_bit(ext_bit),
        .ext_en(ext_en), .line_out(line_out), .port_clk(port_clk),
        .port_sof(port_sof)
    );

    function automatic bit f_active(bit oh, bit mk);
        return oh && (mk || (m_al && m_cnt < N));
    endfunction

    function automatic bit f_out(bit act, bit [2:0] k, bit d, bit eb, bit en);
        if (act && en) return (k == 3'd1) ? (d ^ eb) : eb;
        return d;
    endfunction

    function automatic string f_tag(bit oh, bit act, bit [2:0] k, bit en);
        if (!oh) return "R1";
        if (!en) return "R4";
        if (!act) return "R8";
        if (k == 3'd1) return "R3";
        return "R2";
    endfunction

    task automatic step(bit oh, bit [2:0] k, bit mk, bit d, bit eb, bit en, string tag);
        bit act, e_out, e_sof;
        string t;
        @(negedge clk);
        slot_oh = oh; slot_kind = k; mf_mark = mk;
        line_in = d; ext_bit = eb; ext_en = en;
        act   = rst_n ? f_active(oh, mk) : (oh && mk);
        e_sof = oh && mk;
        e_out = f_out(act, k, d, eb, en);
        t = (tag == "") ? f_tag(oh, act, k, en) : tag;
        #1.5;
        checks++;
        if (line_out !== e_out || port_clk !== act || port_sof !== e_sof) begin
            fails++;
            $display("FAIL %s: out/clk/sof = %b%b%b expected %b%b%b", t,
                     line_out, port_clk, port_sof, e_out, act, e_sof);
        end
        if (rst_n && oh) begin
            if (mk) begin m_al = 1'b1; m_cnt = 1; end
            else if (m_al) begin
                if (m_cnt < N) m_cnt++;
                else begin m_al = 1'b0; m_cnt = 0; end
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog: cycles %0d expected below 150000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4417));
        // R11: held in hunt during reset
        step(1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R11");
        step(1'b1, 3'd2, 1'b0, 1'b1, 1'b0, 1'b1, "R11");
        step(1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R11");
        @(negedge clk); rst_n = 1'b1;
        // R7: unflagged overhead after reset is not served
        step(1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
        step(1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
        // R9: mark on a payload cycle is ignored
        step(1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
        step(1'b1, 3'd3, 1'b0, 1'b1, 1'b0, 1'b1, "R9");
        // R6: flagged start, then a full window of 56 slots
        step(1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, "R6");
        for (int i = 1; i < N; i++) begin
            step(1'b0, 3'd0, 1'b0, i[0], ~i[0], 1'b1, "R1");
            step(1'b1, 3'(i % 5), 1'b0, i[1], i[0], 1'b1, "R5");
        end
        // R8: 57th slot and beyond are not served
        step(1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
        step(1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
        // R10: restart in mid window
        step(1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
        for (int i = 1; i < 10; i++) step(1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1, "R2");
        step(1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, "R10");
        for (int i = 1; i < N; i++) step(1'b1, 3'd1, 1'b0, 1'b1, 1'b1, 1'b1, "R10");
        step(1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, "R10");
        // R4: enable low while aligned
        step(1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
        step(1'b1, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
        // random traffic
        for (int i = 0; i < 20000; i++) begin
            bit oh;
            oh = ($urandom % 4) == 0;
            step(oh, 3'($urandom % 8), ($urandom % 64) == 0, 1'($urandom),
                 1'($urandom), ($urandom % 3) != 0, "");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule